// File: doc/BRIEF.md
# Quadrature Reactive Power Accumulator

This block turns a stream of signed voltage and current samples into an averaged reactive power figure. Each voltage sample enters a leaky first-order integrator. Its output lags the line voltage by close to a quarter period. The integrator's gain falls as line frequency rises, so its output is multiplied by an unsigned correction coefficient that the host supplies for the present line frequency. The corrected quadrature voltage is rounded and clamped back to sample width. It is then multiplied by the current sample of the same index, which gives instantaneous reactive power at the sample rate.

The instantaneous products are summed, and the samples are counted, until an external window-done pulse arrives. That pulse is the same one that closes the active-power window, so both results cover the same N samples. On the pulse the sum and count are captured and the accumulator restarts. A serial divider then forms the signed mean and presents it with a one-cycle valid pulse.

Top module: `qpwr_accum`

## Requirements
- R1: While reset is asserted and after its release, `q_vld` is 0 and `q_avg` is 0 until the first window result appears.
- R2: The integrator state advances only on a cycle with `smp_vld` high, as y[n] = y[n-1] + v[n] - (y[n-1] arithmetic-shifted right by LEAK_SH), which is a floor shift. The state persists across windows.
- R3: The quadrature voltage is y * `coef` / 2^COEF_FRAC, rounded half toward plus infinity. `coef` is unsigned, so with COEF_FRAC=15 a value of 0x8000 is 1.0 and 0 gives a zero result. The result is saturated to the signed SAMP_W range.
- R4: The instantaneous product is the quadrature voltage of sample n times the current sample n, where n is the sample strobed in the same cycle as its voltage.
- R5: A sample strobed in the same cycle as `win_done` belongs to the window being closed. The sum and count restart from zero for the next sample.
- R6: `q_avg` is the window sum divided by the window sample count, truncated toward zero, as a signed 2*SAMP_W value.
- R7: A window that closes with no strobed samples yields `q_avg` = 0.
- R8: Each `win_done` produces exactly one single-cycle `q_vld` pulse. It appears ACC_W+4 clock edges after the edge that samples `win_done`, where ACC_W = 2*SAMP_W + CNT_W. `q_avg` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Strobe: `v_smp` and `i_smp` hold a new sample pair |
| v_smp | input | SAMP_W | Signed voltage sample |
| i_smp | input | SAMP_W | Signed current sample |
| coef | input | COEF_W | Unsigned integrator gain correction, COEF_FRAC fraction bits |
| win_done | input | 1 | Pulse that closes the averaging window |
| q_vld | output | 1 | One-cycle pulse: `q_avg` carries a new result |
| q_avg | output | 2*SAMP_W | Signed average reactive power of the last window |

## Verification
The bench builds the block with SAMP_W=16 and COEF_FRAC=15. It sets LEAK_SH=6, so the integrator settles within tens of samples: a DC input reaches the saturation limit and the leak visibly pulls the state back. It sets CNT_W=8, so the divider finishes in 40 iterations and many windows fit in a short run. Windows cover continuous and gapped strobes, positive and negative means that do not divide evenly, zero and near-2.0 coefficients, an empty window, and a sample coincident with the closing pulse. Each result's arrival cycle is also compared with the expected latency.

// File: rtl/qpwr_pkg.sv
// Shared types for the quadrature reactive power accumulator.
package qpwr_pkg;

    // Serial divider sequencing state.
    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;

endpackage

// File: rtl/qpwr_integ.sv
// Leaky first-order integrator giving a ~90 degree lagged copy of the voltage.
// Assumes INT_W leaves at least two guard bits above SAMP_W+LEAK_SH so the
// bounded steady state (|x| * 2^LEAK_SH) never wraps.
module qpwr_integ #(
    parameter int SAMP_W  = 16,
    parameter int LEAK_SH = 12,
    parameter int INT_W   = SAMP_W + LEAK_SH + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [SAMP_W-1:0] x,
    output logic signed [INT_W-1:0]  y
);

    logic signed [INT_W-1:0] x_ext;
    logic signed [INT_W-1:0] leak;

    // Sign-extend the sample and form the floor-shifted leak term.
    always_comb begin
        x_ext = {{(INT_W-SAMP_W){x[SAMP_W-1]}}, x};
        leak  = y >>> LEAK_SH;
    end

    // Advance the integrator state on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0;
        end else if (en) begin
            y <= y + x_ext - leak;
        end
    end

endmodule

// File: rtl/qpwr_qprod.sv
// Two pipeline stages: gain correction with round-and-clamp to sample width,
// then multiplication by the aligned current sample. Valid and window-done
// flags travel beside the data so the window boundary stays sample-exact.
// Assumes coef is stable while samples are in flight.
module qpwr_qprod #(
    parameter int SAMP_W    = 16,
    parameter int INT_W     = 30,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 15,
    parameter int PROD_W    = 2 * SAMP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic                     in_done,
    input  logic signed [INT_W-1:0]  y,
    input  logic        [COEF_W-1:0] coef,
    input  logic signed [SAMP_W-1:0] cur,
    output logic                     p_vld,
    output logic                     p_done,
    output logic signed [PROD_W-1:0] p
);

    localparam int MW = INT_W + COEF_W + 1;
    localparam logic signed [MW-1:0] RND  = MW'(1) << (COEF_FRAC - 1);
    localparam logic signed [MW-1:0] SMAX = MW'((2 ** (SAMP_W - 1)) - 1);
    localparam logic signed [MW-1:0] SMIN = -SMAX - RND + RND - MW'(1);

    logic signed [MW-1:0]     prod_full;
    logic signed [MW-1:0]     rnd;
    logic signed [MW-1:0]     rnd_sat;
    logic signed [SAMP_W-1:0] vq_b;
    logic signed [SAMP_W-1:0] cur_b;
    logic                     vld_b;
    logic                     done_b;

    // Scale by the correction coefficient, round half up, clamp to range.
    always_comb begin
        prod_full = y * $signed({1'b0, coef});
        rnd       = (prod_full + RND) >>> COEF_FRAC;
        if (rnd > SMAX) begin
            rnd_sat = SMAX;
        end else if (rnd < SMIN) begin
            rnd_sat = SMIN;
        end else begin
            rnd_sat = rnd;
        end
    end

    // Stage B: register corrected quadrature voltage with its current sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vq_b   <= '0;
            cur_b  <= '0;
            vld_b  <= 1'b0;
            done_b <= 1'b0;
        end else begin
            vq_b   <= SAMP_W'(rnd_sat);
            cur_b  <= cur;
            vld_b  <= in_vld;
            done_b <= in_done;
        end
    end

    // Stage C: register the instantaneous quadrature power.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p      <= '0;
            p_vld  <= 1'b0;
            p_done <= 1'b0;
        end else begin
            p      <= vq_b * cur_b;
            p_vld  <= vld_b;
            p_done <= done_b;
        end
    end

endmodule

// File: rtl/qpwr_window.sv
// Window accumulator: sums products and counts samples; on the delayed
// window-done flag it captures sum and count (including a product arriving
// in the same cycle) and restarts from zero. Assumes fewer than 2^CNT_W
// samples per window.
module qpwr_window #(
    parameter int PROD_W = 32,
    parameter int CNT_W  = 16,
    parameter int ACC_W  = PROD_W + CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p_vld,
    input  logic                     p_done,
    input  logic signed [PROD_W-1:0] p,
    output logic                     snap_vld,
    output logic signed [ACC_W-1:0]  snap_sum,
    output logic        [CNT_W-1:0]  snap_cnt
);

    logic signed [ACC_W-1:0] acc;
    logic        [CNT_W-1:0] cnt;
    logic signed [ACC_W-1:0] sum_next;
    logic        [CNT_W-1:0] cnt_next;

    // Running sum and count including the product arriving this cycle.
    always_comb begin
        sum_next = p_vld ? acc + {{(ACC_W-PROD_W){p[PROD_W-1]}}, p} : acc;
        cnt_next = cnt + CNT_W'(p_vld);
    end

    // Accumulate, or capture and restart at the window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            cnt      <= '0;
            snap_sum <= '0;
            snap_cnt <= '0;
            snap_vld <= 1'b0;
        end else if (p_done) begin
            acc      <= '0;
            cnt      <= '0;
            snap_sum <= sum_next;
            snap_cnt <= cnt_next;
            snap_vld <= 1'b1;
        end else begin
            acc      <= sum_next;
            cnt      <= cnt_next;
            snap_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/qpwr_sdiv.sv
// Serial signed-by-unsigned restoring divider, one quotient bit per cycle.
// Result truncates toward zero; a zero divisor yields zero. A new start
// while running restarts with the new operands. Latency: ACC_W edges
// after the edge that samples start.
module qpwr_sdiv #(
    parameter int ACC_W = 48,
    parameter int CNT_W = 16,
    parameter int OUT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [ACC_W-1:0] num,
    input  logic        [CNT_W-1:0] den,
    output logic                    q_vld,
    output logic signed [OUT_W-1:0] q
);
    import qpwr_pkg::*;

    localparam int STEP_W = $clog2(ACC_W);

    dv_state_e           st;
    logic [STEP_W-1:0]   step;
    logic [ACC_W-1:0]    work;
    logic [CNT_W-1:0]    rem;
    logic [CNT_W-1:0]    dvs;
    logic                neg;
    logic [ACC_W-1:0]    num_mag;
    logic [CNT_W:0]      rem_sh;
    logic                ge;
    logic [CNT_W-1:0]    rem_nx;
    logic [ACC_W-1:0]    work_nx;
    logic [ACC_W-1:0]    q_full;

    // Operand magnitude and one restoring step.
    always_comb begin
        num_mag = num[ACC_W-1] ? ACC_W'(-num) : ACC_W'(num);
        rem_sh  = {rem, work[ACC_W-1]};
        ge      = rem_sh >= {1'b0, dvs};
        rem_nx  = ge ? CNT_W'(rem_sh - {1'b0, dvs}) : CNT_W'(rem_sh);
        work_nx = {work[ACC_W-2:0], ge};
        if (dvs == '0) begin
            q_full = '0;
        end else if (neg) begin
            q_full = -work_nx;
        end else begin
            q_full = work_nx;
        end
    end

    // Load operands, iterate, and publish the quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= DV_IDLE;
            step  <= '0;
            work  <= '0;
            rem   <= '0;
            dvs   <= '0;
            neg   <= 1'b0;
            q_vld <= 1'b0;
            q     <= '0;
        end else begin
            q_vld <= 1'b0;
            if (start) begin
                st   <= DV_RUN;
                step <= '0;
                work <= num_mag;
                rem  <= '0;
                dvs  <= den;
                neg  <= num[ACC_W-1];
            end else if (st == DV_RUN) begin
                work <= work_nx;
                rem  <= rem_nx;
                step <= step + 1'b1;
                if (step == STEP_W'(ACC_W - 1)) begin
                    st    <= DV_IDLE;
                    q_vld <= 1'b1;
                    q     <= OUT_W'(q_full);
                end
            end
        end
    end

endmodule

// File: rtl/qpwr_accum.sv
// Top: quadrature reactive power over a host-defined sample window.
// Pipeline: integrator (stage A) -> gain correction (B) -> product (C)
// -> window accumulation (D) -> serial divider. win_done is delayed along
// with the samples so the window boundary is exact. Assumes coef is stable
// while samples are in flight and window-done pulses are at least ACC_W+1
// cycles apart.
module qpwr_accum #(
    parameter int SAMP_W    = 16,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 15,
    parameter int LEAK_SH   = 12,
    parameter int CNT_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic signed [SAMP_W-1:0]   v_smp,
    input  logic signed [SAMP_W-1:0]   i_smp,
    input  logic        [COEF_W-1:0]   coef,
    input  logic                       win_done,
    output logic                       q_vld,
    output logic signed [2*SAMP_W-1:0] q_avg
);

    localparam int INT_W  = SAMP_W + LEAK_SH + 2;
    localparam int PROD_W = 2 * SAMP_W;
    localparam int ACC_W  = PROD_W + CNT_W;

    logic signed [INT_W-1:0]  integ_y;
    logic signed [SAMP_W-1:0] i_a;
    logic                     vld_a;
    logic                     done_a;
    logic                     p_vld;
    logic                     p_done;
    logic signed [PROD_W-1:0] p;
    logic                     snap_vld;
    logic signed [ACC_W-1:0]  snap_sum;
    logic        [CNT_W-1:0]  snap_cnt;

    qpwr_integ #(
        .SAMP_W (SAMP_W),
        .LEAK_SH(LEAK_SH),
        .INT_W  (INT_W)
    ) u_integ (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (smp_vld),
        .x    (v_smp),
        .y    (integ_y)
    );

    // Stage A: hold current sample and flags beside the integrator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_a    <= '0;
            vld_a  <= 1'b0;
            done_a <= 1'b0;
        end else begin
            i_a    <= i_smp;
            vld_a  <= smp_vld;
            done_a <= win_done;
        end
    end

    qpwr_qprod #(
        .SAMP_W   (SAMP_W),
        .INT_W    (INT_W),
        .COEF_W   (COEF_W),
        .COEF_FRAC(COEF_FRAC),
        .PROD_W   (PROD_W)
    ) u_qprod (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (vld_a),
        .in_done(done_a),
        .y      (integ_y),
        .coef   (coef),
        .cur    (i_a),
        .p_vld  (p_vld),
        .p_done (p_done),
        .p      (p)
    );

    qpwr_window #(
        .PROD_W(PROD_W),
        .CNT_W (CNT_W),
        .ACC_W (ACC_W)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .p_vld   (p_vld),
        .p_done  (p_done),
        .p       (p),
        .snap_vld(snap_vld),
        .snap_sum(snap_sum),
        .snap_cnt(snap_cnt)
    );

    qpwr_sdiv #(
        .ACC_W(ACC_W),
        .CNT_W(CNT_W),
        .OUT_W(PROD_W)
    ) u_sdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .start(snap_vld),
        .num  (snap_sum),
        .den  (snap_cnt),
        .q_vld(q_vld),
        .q    (q_avg)
    );

endmodule

// File: rtl/qpwr_accum_chk.sv
// Property checker bound to qpwr_accum; observes ports and stage outputs.
module qpwr_accum_chk #(
    parameter int INT_W = 30,
    parameter int OUT_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_vld,
    input logic                    win_done,
    input logic signed [INT_W-1:0] integ_y,
    input logic                    snap_vld,
    input logic                    q_vld,
    input logic signed [OUT_W-1:0] q_avg
);

    // R2
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(integ_y));

    // R5
    win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> ##4 snap_vld);

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_vld |=> !q_vld);

    // R8
    avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_vld |-> $stable(q_avg));

    // R1
    rst_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_vld && q_avg == '0));

endmodule

bind qpwr_accum qpwr_accum_chk #(
    .INT_W(INT_W),
    .OUT_W(PROD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .win_done(win_done),
    .integ_y (integ_y),
    .snap_vld(snap_vld),
    .q_vld   (q_vld),
    .q_avg   (q_avg)
);

// File: tb/sim_qpwr_accum.sv
`timescale 1ns/1ps
module sim_qpwr_accum;

    localparam int SW    = 16;
    localparam int CW    = 16;
    localparam int CF    = 15;
    localparam int LS    = 6;
    localparam int NW    = 8;
    localparam int ACCW  = 2 * SW + NW;
    localparam longint SMAX = (64'sd1 <<< (SW - 1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (SW - 1));

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   smp_vld = 1'b0;
    logic signed [SW-1:0]   v_smp = '0;
    logic signed [SW-1:0]   i_smp = '0;
    logic        [CW-1:0]   coef = '0;
    logic                   win_done = 1'b0;
    logic                   q_vld;
    logic signed [2*SW-1:0] q_avg;

    typedef struct {
        longint val;
        longint due;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     errs = 0;
    int     chks = 0;
    longint cyc = 0;
    longint my = 0;
    longint msum = 0;
    int     mcnt = 0;
    bit     ended = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    qpwr_accum #(
        .SAMP_W(SW), .COEF_W(CW), .COEF_FRAC(CF), .LEAK_SH(LS), .CNT_W(NW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .v_smp(v_smp),
        .i_smp(i_smp), .coef(coef), .win_done(win_done),
        .q_vld(q_vld), .q_avg(q_avg)
    );

    function automatic longint sat(input longint x);
        if (x > SMAX) return SMAX;
        if (x < SMIN) return SMIN;
        return x;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input bit s, input int v, input int i, input bit d,
                        input string tag);
        longint vq;
        @(negedge clk);
        smp_vld  = s;
        v_smp    = SW'(v);
        i_smp    = SW'(i);
        win_done = d;
        if (s) begin
            my   = my + longint'(v) - (my >>> LS);
            vq   = sat((my * longint'(coef) + (64'sd1 <<< (CF - 1))) >>> CF);
            msum = msum + vq * longint'(i);
            mcnt = mcnt + 1;
        end
        if (d) begin
            exp_t e;
            e.val = (mcnt == 0) ? 0 : msum / longint'(mcnt);
            e.due = cyc + 5 + ACCW;
            e.tag = tag;
            sb.push_back(e);
            msum = 0;
            mcnt = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 0, 1'b0, "");
    endtask

    task automatic close(input string tag);
        step(1'b0, 0, 0, 1'b1, tag);
        idle(50);
    endtask

    // Monitor: compare each result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && q_vld) begin
            chks++;
            if (sb.size() == 0) begin
                errs++;
                $display("FAIL R8: unexpected q_vld, q_avg=%0d expected no result", q_avg);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (longint'(q_avg) != e.val || cyc != e.due) begin
                    errs++;
                    $display("FAIL %s: q_avg=%0d at cycle %0d expected %0d at cycle %0d",
                             e.tag, q_avg, cyc, e.val, e.due);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errs++;
            chks++;
            $display("FAIL watchdog: run did not finish, pending=%0d expected 0", sb.size());
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs idle during and right after reset
        chks++;
        if (q_vld !== 1'b0 || q_avg !== '0) begin
            errs++;
            $display("FAIL R1: q_vld=%0b q_avg=%0d expected 0 0", q_vld, q_avg);
        end
        rst_n = 1'b1;
        idle(3);
        chks++;
        if (q_vld !== 1'b0 || q_avg !== '0) begin
            errs++;
            $display("FAIL R1: after release q_vld=%0b q_avg=%0d expected 0 0", q_vld, q_avg);
        end

        // R2 R4: DC voltage, unity coefficient, continuous strobes
        coef = 16'h8000;
        for (int k = 0; k < 20; k++) step(1'b1, 1000, 500, 1'b0, "");
        close("R2 R4 dc");

        // R3: large DC drives the quadrature voltage into saturation
        for (int k = 0; k < 40; k++) step(1'b1, 30000, -7000, 1'b0, "");
        close("R3 saturation");

        // R2 R3: half gain, alternating odd voltage, strobes with gaps
        coef = 16'h4000;
        for (int k = 0; k < 30; k++) begin
            step(1'b1, (k % 2 == 0) ? 123 : -77, 301 - 17 * k, 1'b0, "");
            step(1'b0, 9999, 9999, 1'b0, "");
        end
        close("R2 R3 gaps");

        // R7: window with no strobed samples
        close("R7 empty");

        // R5: sample coincident with window-done is counted in the closing window
        coef = 16'h2345;
        for (int k = 0; k < 12; k++) step(1'b1, 2000 - 300 * k, 40 * k - 200, 1'b0, "");
        step(1'b1, -5000, 3000, 1'b1, "R5 coincident");
        for (int k = 0; k < 5; k++) step(1'b1, 700, -900, 1'b0, "");
        idle(50);
        close("R5 next window");

        // R3: zero coefficient gives zero product
        coef = 16'h0000;
        for (int k = 0; k < 15; k++) step(1'b1, 8000 - 900 * k, 5000, 1'b0, "");
        close("R3 zero coef");

        // R6: negative mean that does not divide evenly
        coef = 16'h8000;
        for (int k = 0; k < 7; k++) step(1'b1, -37 * (k + 1), 13 + k, 1'b0, "");
        close("R6 truncate neg");

        // R6: positive mean, uneven count
        for (int k = 0; k < 11; k++) step(1'b1, 251 * (k % 4) - 300, -19 - 3 * k, 1'b0, "");
        close("R6 truncate pos");

        // R3 R4: near-2.0 coefficient, triangle voltage, sign-changing current
        coef = 16'hFFFF;
        for (int k = 0; k < 48; k++)
            step(1'b1, ((k % 16) < 8 ? (k % 16) : 16 - (k % 16)) * 900 - 3600,
                 (k % 12 < 6) ? 2500 : -1800, 1'b0, "");
        close("R3 R4 triangle");

        // R8: every window-done produced a result
        idle(60);
        chks++;
        if (sb.size() != 0) begin
            errs++;
            $display("FAIL R8: pending results=%0d expected 0", sb.size());
        end
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

endmodule